// File: doc/BRIEF.md
# Processor Operating Mode Controller

This block holds the architectural control state that decides which execution mode a processor core is in. Three control registers (indexed 0, 3 and 4) are written through a simple control-register write bus. An extended feature register is reached through a separate indexed port that has a 32-bit index and supports both writes and reads. From this state, from a level input that carries the virtual-8086 flag, and from the long attribute of the current code segment, the block derives the current operating mode. It also derives the matching linear-address width.

Some writes would break the entry order: long mode may only be entered from protected mode, and only after address extension and long enable are both in place. Such writes are refused and produce a one-cycle fault pulse. An access to an extended index that is not implemented also produces the fault pulse. Instruction decode, page walks and descriptor loading are outside this block; a core uses its outputs to choose how it forms addresses.

Top module: `opmode_ctrl`

## Requirements
- R1: After reset the mode is real (code 0), the address width is 20, the fault output is 0 and control registers 0, 3 and 4 read back as zero.
- R2: In real mode, a write of control register 0 with bit 0 set and bit 31 clear gives protected mode (code 1) with address width 32. The register reads back the written value.
- R3: While the register state selects protected mode without long mode, vm_flag high gives virtual-8086 mode (code 2) with width 20, and vm_flag low gives protected mode. In real and long modes vm_flag has no effect on the outputs.
- R4: The extended register sits at index 0xC0000080. Only bit 8 (long enable) is writable. A read returns bit 8, bit 10 (long active, read-only) and zeros elsewhere on ext_rdata, starting in the cycle after the read.
- R5: A control register 0 write that raises bit 31 while bit 0 is already set, control register 4 bit 5 is set and long enable is set makes long mode active. The mode is then code 3 with width 48 when cs_long_attr is high, and code 4 with width 32 when it is low.
- R6: A write that raises bit 31 while long enable is set and control register 4 bit 5 is clear is refused. Control register 0 and the mode keep their values, and fault is high for one cycle.
- R7: A control register 0 write that sets bit 31 while bit 0 is currently clear, or that writes bit 31 set with bit 0 clear, is refused with a fault. Long mode is therefore never entered directly from real mode.
- R8: A write to the extended register that would change long enable while control register 0 bit 31 is set is ignored and raises fault.
- R9: A read from an unimplemented extended index returns zero and raises fault. A write to such an index changes nothing and raises fault.
- R10: Clearing control register 0 bit 31 while long mode is active leaves long mode: the mode becomes protected and bit 10 of the extended register reads 0.
- R11: While long mode is active, a control register 4 write that clears bit 5 is refused with a fault, and control register 4 keeps its value.
- R12: Control register 3 holds the value written to it. A control register write to any index other than 0, 3 or 4 raises fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_wr_idx | input | 4 | Control-register write index |
| cr_wr_data | input | 32 | Control-register write data |
| cr_rd_idx | input | 4 | Control-register read index |
| cr_rd_data | output | 32 | Current value of the indexed control register |
| ext_en | input | 1 | Extended-register access strobe |
| ext_wr | input | 1 | 1 = write, 0 = read |
| ext_idx | input | 32 | Extended-register index |
| ext_wdata | input | 32 | Extended-register write data |
| ext_rdata | output | 32 | Read data, registered |
| vm_flag | input | 1 | Virtual-8086 flag level |
| cs_long_attr | input | 1 | Long attribute of the current code segment |
| mode | output | 3 | 0 real, 1 protected, 2 virtual-8086, 3 long 64-bit, 4 compatibility |
| addr_width | output | 6 | Linear-address width in bits |
| fault | output | 1 | One-cycle pulse on a refused or illegal access |

## Verification
Register writes take effect at the clock edge that samples them. From that edge on, mode, addr_width and cr_rd_data show the new state, because these outputs are combinational from the registers. fault and ext_rdata are registered and are valid in the cycle that follows the same edge. vm_flag and cs_long_attr change mode at once, with no edge needed. The driver applies each stimulus on a falling edge and queues the expected values. The monitor compares them a short time after the next rising edge, so every result is sampled exactly one edge after its stimulus.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
   typedef enum logic [2:0] {
      OM_REAL   = 3'd0,
      OM_PROT   = 3'd1,
      OM_V86    = 3'd2,
      OM_LONG64 = 3'd3,
      OM_COMPAT = 3'd4
   } opmode_e;

   localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/opmode_crfile.sv
module opmode_crfile #(
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned PE_BIT  = 0,
   parameter int unsigned PG_BIT  = 31,
   parameter int unsigned PAE_BIT = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [opmode_pkg::WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [opmode_pkg::WORD_W-1:0] rd_data,
   input  logic                          lme,
   output logic                          pe,
   output logic                          pg,
   output logic                          long_act,
   output logic                          bad
);
   localparam int unsigned W = opmode_pkg::WORD_W;
   localparam logic [IDX_W-1:0] IDX0 = IDX_W'(0);
   localparam logic [IDX_W-1:0] IDX3 = IDX_W'(3);
   localparam logic [IDX_W-1:0] IDX4 = IDX_W'(4);

   logic [W-1:0] r0_q, r3_q, r4_q, r0_n, r3_n, r4_n;
   logic         lact_q, lact_n;
   logic         pg_rise;

   always_comb begin
      r0_n    = r0_q;
      r3_n    = r3_q;
      r4_n    = r4_q;
      lact_n  = lact_q;
      bad     = 1'b0;
      pg_rise = wr_data[PG_BIT] & ~r0_q[PG_BIT];
      if (wr_en) begin
         unique case (wr_idx)
            IDX0: begin
               if (wr_data[PG_BIT] & ~wr_data[PE_BIT])     bad = 1'b1;
               else if (pg_rise & ~r0_q[PE_BIT])           bad = 1'b1;
               else if (pg_rise & lme & ~r4_q[PAE_BIT])    bad = 1'b1;
               if (!bad) begin
                  r0_n = wr_data;
                  if (!wr_data[PG_BIT])  lact_n = 1'b0;
                  else if (pg_rise)      lact_n = lme;
               end
            end
            IDX3: r3_n = wr_data;
            IDX4: begin
               if (lact_q & ~wr_data[PAE_BIT]) bad = 1'b1;
               else                             r4_n = wr_data;
            end
            default: bad = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r0_q   <= '0;
         r3_q   <= '0;
         r4_q   <= '0;
         lact_q <= 1'b0;
      end else begin
         r0_q   <= r0_n;
         r3_q   <= r3_n;
         r4_q   <= r4_n;
         lact_q <= lact_n;
      end
   end

   always_comb begin
      unique case (rd_idx)
         IDX0:    rd_data = r0_q;
         IDX3:    rd_data = r3_q;
         IDX4:    rd_data = r4_q;
         default: rd_data = '0;
      endcase
   end

   assign pe       = r0_q[PE_BIT];
   assign pg       = r0_q[PG_BIT];
   assign long_act = lact_q;
endmodule

// File: rtl/opmode_xreg.sv
module opmode_xreg #(
   parameter logic [31:0] XR_INDEX = 32'hC000_0080,
   parameter int unsigned LME_BIT  = 8,
   parameter int unsigned LMA_BIT  = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          en,
   input  logic                          wr,
   input  logic [31:0]                   idx,
   input  logic [opmode_pkg::WORD_W-1:0] wdata,
   input  logic                          pg,
   input  logic                          long_act,
   output logic                          lme,
   output logic [opmode_pkg::WORD_W-1:0] rdata,
   output logic                          bad
);
   localparam int unsigned W = opmode_pkg::WORD_W;
   localparam logic [W-1:0] WR_MASK = W'(1) << LME_BIT;
   localparam logic [W-1:0] ST_MASK = W'(1) << LMA_BIT;

   logic [W-1:0] x_q, x_n, view;
   logic         hit;

   assign hit = (idx == XR_INDEX);
   assign lme = x_q[LME_BIT];

   always_comb begin
      x_n = x_q;
      bad = 1'b0;
      if (en) begin
         if (!hit) begin
            bad = 1'b1;
         end else if (wr) begin
            if (pg && (wdata[LME_BIT] != x_q[LME_BIT])) bad = 1'b1;
            else                                         x_n = wdata & WR_MASK;
         end
      end
   end

   assign view = (x_q & WR_MASK) | (long_act ? ST_MASK : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q   <= '0;
         rdata <= '0;
      end else begin
         x_q <= x_n;
         if (en && !wr) rdata <= hit ? view : '0;
      end
   end
endmodule

// File: rtl/opmode_decode.sv
module opmode_decode #(
   parameter int unsigned REAL_AW = 20,
   parameter int unsigned PROT_AW = 32,
   parameter int unsigned LONG_AW = 48,
   localparam int unsigned AW_W   = $clog2(LONG_AW + 1)
) (
   input  logic            pe,
   input  logic            long_act,
   input  logic            vm_flag,
   input  logic            cs_long,
   output logic [2:0]      mode,
   output logic [AW_W-1:0] addr_w
);
   import opmode_pkg::*;
   opmode_e m;

   always_comb begin
      if (!pe)          m = OM_REAL;
      else if (long_act) m = cs_long ? OM_LONG64 : OM_COMPAT;
      else if (vm_flag) m = OM_V86;
      else              m = OM_PROT;
   end

   always_comb begin
      unique case (m)
         OM_REAL, OM_V86:   addr_w = AW_W'(REAL_AW);
         OM_LONG64:         addr_w = AW_W'(LONG_AW);
         default:           addr_w = AW_W'(PROT_AW);
      endcase
   end

   assign mode = m;
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl #(
   parameter int unsigned IDX_W    = 4,
   parameter logic [31:0] XR_INDEX = 32'hC000_0080,
   parameter int unsigned PE_BIT   = 0,
   parameter int unsigned PG_BIT   = 31,
   parameter int unsigned PAE_BIT  = 5,
   parameter int unsigned LME_BIT  = 8,
   parameter int unsigned LMA_BIT  = 10,
   parameter int unsigned REAL_AW  = 20,
   parameter int unsigned PROT_AW  = 32,
   parameter int unsigned LONG_AW  = 48,
   localparam int unsigned AW_W    = $clog2(LONG_AW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cr_wr_en,
   input  logic [IDX_W-1:0] cr_wr_idx,
   input  logic [31:0]      cr_wr_data,
   input  logic [IDX_W-1:0] cr_rd_idx,
   output logic [31:0]      cr_rd_data,
   input  logic             ext_en,
   input  logic             ext_wr,
   input  logic [31:0]      ext_idx,
   input  logic [31:0]      ext_wdata,
   output logic [31:0]      ext_rdata,
   input  logic             vm_flag,
   input  logic             cs_long_attr,
   output logic [2:0]       mode,
   output logic [AW_W-1:0]  addr_width,
   output logic             fault
);
   localparam int unsigned W = opmode_pkg::WORD_W;

   generate
      if (PE_BIT >= W || PG_BIT >= W || PAE_BIT >= W) begin : g_bad_cr_bit
         $error("opmode_ctrl: control bit position out of range");
      end
      if (LME_BIT >= W || LMA_BIT >= W || LME_BIT == LMA_BIT) begin : g_bad_x_bit
         $error("opmode_ctrl: extended register bit positions invalid");
      end
      if (PE_BIT == PG_BIT) begin : g_bad_cr0
         $error("opmode_ctrl: enable and paging bits must differ");
      end
      if (!(REAL_AW < PROT_AW && PROT_AW < LONG_AW)) begin : g_bad_aw
         $error("opmode_ctrl: address widths must increase by mode");
      end
      if (IDX_W < 3) begin : g_bad_idx
         $error("opmode_ctrl: index width too small for register 4");
      end
   endgenerate

   logic pe, pg, long_act, lme, cr_bad, x_bad, fault_q;

   opmode_crfile #(
      .IDX_W(IDX_W), .PE_BIT(PE_BIT), .PG_BIT(PG_BIT), .PAE_BIT(PAE_BIT)
   ) crfile_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cr_wr_en), .wr_idx(cr_wr_idx), .wr_data(cr_wr_data),
      .rd_idx(cr_rd_idx), .rd_data(cr_rd_data),
      .lme(lme), .pe(pe), .pg(pg), .long_act(long_act), .bad(cr_bad)
   );

   opmode_xreg #(
      .XR_INDEX(XR_INDEX), .LME_BIT(LME_BIT), .LMA_BIT(LMA_BIT)
   ) xreg_i (
      .clk(clk), .rst_n(rst_n),
      .en(ext_en), .wr(ext_wr), .idx(ext_idx), .wdata(ext_wdata),
      .pg(pg), .long_act(long_act), .lme(lme), .rdata(ext_rdata), .bad(x_bad)
   );

   opmode_decode #(
      .REAL_AW(REAL_AW), .PROT_AW(PROT_AW), .LONG_AW(LONG_AW)
   ) decode_i (
      .pe(pe), .long_act(long_act), .vm_flag(vm_flag), .cs_long(cs_long_attr),
      .mode(mode), .addr_w(addr_width)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) fault_q <= 1'b0;
      else        fault_q <= cr_bad | x_bad;
   end

   assign fault = fault_q;
endmodule

// File: rtl/opmode_ctrl_chk.sv
module opmode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cr_wr_en,
   input logic       ext_en,
   input logic       vm_flag,
   input logic       cs_long_attr,
   input logic [2:0] mode,
   input logic       fault
);
   import opmode_pkg::*;

   logic in_long;
   assign in_long = (mode == OM_LONG64) || (mode == OM_COMPAT);

   assert_real_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OM_REAL && !cr_wr_en) |=> (mode == OM_REAL));

   assert_v86_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OM_V86) |-> vm_flag);

   assert_submode_attr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_long |-> (cs_long_attr == (mode == OM_LONG64)));

   assert_long_via_prot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OM_REAL) |=> !in_long);

   assert_fault_needs_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cr_wr_en || ext_en) |=> !fault);

   assert_long_exit_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_long && !cr_wr_en) |=> in_long);
endmodule

bind opmode_ctrl opmode_ctrl_chk chk_i (
   .clk(clk), .rst_n(rst_n), .cr_wr_en(cr_wr_en), .ext_en(ext_en),
   .vm_flag(vm_flag), .cs_long_attr(cs_long_attr), .mode(mode), .fault(fault)
);

// File: tb/opmode_ctrl_tb_top.sv
`timescale 1ns/1ps
module opmode_ctrl_tb_top;
   localparam logic [31:0] XI = 32'hC000_0080;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cr_wr_en = 1'b0;
   logic [3:0]  cr_wr_idx = '0;
   logic [31:0] cr_wr_data = '0;
   logic [3:0]  cr_rd_idx = '0;
   logic [31:0] cr_rd_data;
   logic        ext_en = 1'b0;
   logic        ext_wr = 1'b0;
   logic [31:0] ext_idx = '0;
   logic [31:0] ext_wdata = '0;
   logic [31:0] ext_rdata;
   logic        vm_flag = 1'b0;
   logic        cs_long_attr = 1'b0;
   logic [2:0]  mode;
   logic [5:0]  addr_width;
   logic        fault;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   opmode_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .cr_wr_en(cr_wr_en), .cr_wr_idx(cr_wr_idx), .cr_wr_data(cr_wr_data),
      .cr_rd_idx(cr_rd_idx), .cr_rd_data(cr_rd_data),
      .ext_en(ext_en), .ext_wr(ext_wr), .ext_idx(ext_idx), .ext_wdata(ext_wdata),
      .ext_rdata(ext_rdata), .vm_flag(vm_flag), .cs_long_attr(cs_long_attr),
      .mode(mode), .addr_width(addr_width), .fault(fault)
   );

   typedef struct {
      string       tag;
      int          m;
      int          aw;
      bit          f;
      logic [31:0] cr;
      bit          cx;
      logic [31:0] x;
   } exp_t;

   exp_t expq[$];

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Monitor: compares one queued item a little after each rising edge
   always @(posedge clk) begin
      #2;
      if (expq.size() > 0) begin
         exp_t e;
         e = expq.pop_front();
         chk(e.tag, "mode", 32'(mode), 32'(e.m));
         chk(e.tag, "addr_width", 32'(addr_width), 32'(e.aw));
         chk(e.tag, "fault", 32'(fault), 32'(e.f));
         chk(e.tag, "cr_rd_data", cr_rd_data, e.cr);
         if (e.cx) chk(e.tag, "ext_rdata", ext_rdata, e.x);
      end
   end

   task automatic wr_cr(input logic [3:0] i, input logic [31:0] d);
      cr_wr_en = 1'b1; cr_wr_idx = i; cr_wr_data = d;
   endtask

   task automatic acc_x(input logic w, input logic [31:0] i, input logic [31:0] d);
      ext_en = 1'b1; ext_wr = w; ext_idx = i; ext_wdata = d;
   endtask

   // Driver: stimulus is already set at this falling edge; queue expectation, advance
   task automatic step(input string tag, input int m, input int aw, input bit f,
                       input logic [31:0] cr, input bit cx = 0, input logic [31:0] x = '0);
      exp_t e;
      e.tag = tag; e.m = m; e.aw = aw; e.f = f; e.cr = cr; e.cx = cx; e.x = x;
      expq.push_back(e);
      @(negedge clk);
      cr_wr_en = 1'b0;
      ext_en = 1'b0;
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "mode in reset", 32'(mode), 32'd0);
      chk("R1", "fault in reset", 32'(fault), 32'd0);
      chk("R1", "width in reset", 32'(addr_width), 32'd20);
      rst_n = 1'b1;

      // R1: reset state of registers
      cr_rd_idx = 0; step("R1", 0, 20, 0, 32'h0);
      cr_rd_idx = 3; step("R1", 0, 20, 0, 32'h0);
      cr_rd_idx = 4; step("R1", 0, 20, 0, 32'h0);
      // R12: register 3 holds data, bad index faults
      cr_rd_idx = 3; wr_cr(3, 32'h0012_3000); step("R12", 0, 20, 0, 32'h0012_3000);
      cr_rd_idx = 0; wr_cr(7, 32'h1); step("R12", 0, 20, 1, 32'h0);
      // R7: paging from real refused
      wr_cr(0, 32'h8000_0001); step("R7", 0, 20, 1, 32'h0);
      // R3: vm flag ignored in real mode
      vm_flag = 1; step("R3", 0, 20, 0, 32'h0);
      vm_flag = 0;
      // R2: enter protected
      wr_cr(0, 32'h0000_0001); step("R2", 1, 32, 0, 32'h1);
      // R7: paging bit with enable bit clear refused
      wr_cr(0, 32'h8000_0000); step("R7", 1, 32, 1, 32'h1);
      // R3: virtual-8086 follows flag
      vm_flag = 1; step("R3", 2, 20, 0, 32'h1);
      vm_flag = 0; step("R3", 1, 32, 0, 32'h1);
      // R4: only bit 8 writable
      acc_x(1, XI, 32'hFFFF_FFFF); step("R4", 1, 32, 0, 32'h1);
      acc_x(0, XI, 32'h0); step("R4", 1, 32, 0, 32'h1, 1, 32'h0000_0100);
      // R6: paging without address extension refused
      wr_cr(0, 32'h8000_0001); step("R6", 1, 32, 1, 32'h1);
      step("R6", 1, 32, 0, 32'h1);
      cr_rd_idx = 4; wr_cr(4, 32'h0000_0020); step("R5", 1, 32, 0, 32'h20);
      // R5: long entry, compatibility then 64-bit
      cr_rd_idx = 0; cs_long_attr = 0;
      wr_cr(0, 32'h8000_0001); step("R5", 4, 32, 0, 32'h8000_0001);
      acc_x(0, XI, 32'h0); step("R4", 4, 32, 0, 32'h8000_0001, 1, 32'h0000_0500);
      cs_long_attr = 1; step("R5", 3, 48, 0, 32'h8000_0001);
      // R3: vm flag ignored in long mode
      vm_flag = 1; step("R3", 3, 48, 0, 32'h8000_0001);
      vm_flag = 0;
      // R8: long enable change while paging is refused
      acc_x(1, XI, 32'h0); step("R8", 3, 48, 1, 32'h8000_0001);
      acc_x(0, XI, 32'h0); step("R8", 3, 48, 0, 32'h8000_0001, 1, 32'h0000_0500);
      // R11: clearing extension in long mode refused
      cr_rd_idx = 4; wr_cr(4, 32'h0); step("R11", 3, 48, 1, 32'h20);
      // R9: unimplemented extended index
      acc_x(0, 32'h0000_1234, 32'h0); step("R9", 3, 48, 1, 32'h20, 1, 32'h0);
      acc_x(1, 32'h0000_1234, 32'hFFFF_FFFF); step("R9", 3, 48, 1, 32'h20);
      acc_x(0, XI, 32'h0); step("R9", 3, 48, 0, 32'h20, 1, 32'h0000_0500);
      // R10: leave long mode by clearing paging
      cr_rd_idx = 0; wr_cr(0, 32'h0000_0001); step("R10", 1, 32, 0, 32'h1);
      acc_x(0, XI, 32'h0); step("R10", 1, 32, 0, 32'h1, 1, 32'h0000_0100);
      // R2: back to real
      wr_cr(0, 32'h0); step("R2", 0, 20, 0, 32'h0);
      step("R1", 0, 20, 0, 32'h0);

      @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule